// File: doc/BRIEF.md
# Timed Lock and Fuse Access Controller

This block sits beside a microcontroller core's program-memory path. It decides when a load or store of program memory goes to the fuse and lock storage instead of the flash array. Software arms it by writing a control register with both an enable bit and a lock-select bit set. Arming opens two short windows that count cycles from the arming write. A load issued inside the shorter window returns a fuse byte or the lock byte, chosen by the Z address. A store issued inside the longer window programs boot lock bits from the R0 data.

The control bits clear themselves once a special access finishes, or once the store window runs out unused. While the EEPROM reports a write in progress, the block refuses control writes and does not redirect loads or stores. Loads that are not redirected return the word presented on the flash read port, registered one cycle later like every other read.

Top module: `lock_fuse_access`

## Requirements
- R1: After reset `ctrlBits` is 00 and `rdValid` is 0. The lock bits hold `LOCK_INIT` (default all 1) and the fuse bytes hold `FUSE_LO_INIT` and `FUSE_HI_INIT`.
- R2: A control write takes the enable flag from bit 0 and the lock-select flag from bit 3 of `ctrlWrData`. `ctrlBits` shows {lock-select, enable}. The block is armed only while both flags are 1.
- R3: A load sampled 1, 2 or 3 cycles after an arming write is a special read. Its result appears on `rdData` with `rdValid` one cycle later, and both control flags are 0 after that edge.
- R4: A store sampled 1 to 4 cycles after an arming write programs lock bits and clears both control flags. A store sampled after the flags have cleared changes nothing.
- R5: If no special access uses the windows, the flags clear at the edge 4 cycles after the write. A load sampled 4 cycles after the write returns flash data.
- R6: In a special read, Z = 0x0000 returns the low fuse byte, 0x0001 the lock byte and 0x0003 the high fuse byte. Any other Z returns 0xFF.
- R7: In the lock byte, bits 7:6 read 1 and bits 5:0 hold the six lock bits. A programmed bit reads 0 and an unprogrammed bit reads 1.
- R8: In a lock store, each zero among R0 bits 5..2 programs lock bit 5..2 at the same position. Z is ignored, and lock bits 1:0 are not changed.
- R9: A lock bit never goes from 0 back to 1 except through reset.
- R10: While `eepromBusy` is 1, control writes are ignored. In that state a windowed load returns flash data and a windowed store changes nothing.
- R11: Every load that is not a special read returns `flashRdData`, as sampled with the load, one cycle later with `rdValid`.
- R12: A new arming write restarts the window count from zero.
- R13: Reset applied inside an open window clears both flags and closes the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 8 | Control write data (bit 0 enable, bit 3 lock-select) |
| opValid | input | 1 | Program-memory operation strobe |
| opIsStore | input | 1 | 1 = store, 0 = load |
| opAddr | input | 16 | Z address of the operation |
| opData | input | 8 | R0 data of a store |
| eepromBusy | input | 1 | EEPROM write in progress |
| flashRdData | input | 8 | Flash word for the current load |
| rdData | output | 8 | Registered load result |
| rdValid | output | 1 | Load result valid |
| ctrlBits | output | 2 | Current {lock-select, enable} flags |

## Verification
A miscounted window is visible on the ports. A special read then returns flash data instead of a fuse or lock byte, or the reverse, and the wrong value shows on `rdData` one cycle after the edge where the load was sampled. An auto-clear that comes early or late shows on `ctrlBits` at the fourth edge after arming. Corrupt lock storage shows only when the lock byte is read back. So every store is followed by a windowed read of Z = 0x0001, which brings a wrong or reversed bit to the ports within a few cycles.

// File: rtl/lock_fuse_pkg.sv
package lock_fuse_pkg;
  typedef struct packed {
    logic specialRd;
    logic flashRd;
    logic lockPgm;
  } lfaStrobe_t;
endpackage

// File: rtl/lfa_ctrl.sv
module lfa_ctrl
  import lock_fuse_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LOAD_WIN  = 3,
  parameter int STORE_WIN = 4,
  parameter int EN_BIT    = 0,
  parameter int SEL_BIT   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [DATA_W-1:0] ctrlWrData,
  input  logic              opValid,
  input  logic              opIsStore,
  input  logic              eepromBusy,
  output lfaStrobe_t        strb,
  output logic [1:0]        ctrlBits
);
  localparam int CNT_W = $clog2(STORE_WIN + 1);
  localparam logic [CNT_W-1:0] LOAD_LAST  = CNT_W'(LOAD_WIN - 1);
  localparam logic [CNT_W-1:0] STORE_LAST = CNT_W'(STORE_WIN - 1);

  logic             enQ, selQ;
  logic [CNT_W-1:0] cntQ;
  logic             armed, anySet, acceptWr, inLoadWin, inStoreWin;
  logic             isLoad, isStore, expire;

  assign armed      = enQ & selQ;
  assign anySet     = enQ | selQ;
  assign acceptWr   = ctrlWrEn & ~eepromBusy;
  assign inLoadWin  = armed & (cntQ <= LOAD_LAST);
  assign inStoreWin = armed & (cntQ <= STORE_LAST);
  assign isLoad     = opValid & ~opIsStore;
  assign isStore    = opValid & opIsStore;
  assign expire     = anySet & (cntQ == STORE_LAST);

  always_comb begin
    strb.specialRd = isLoad & inLoadWin & ~eepromBusy;
    strb.lockPgm   = isStore & inStoreWin & ~eepromBusy;
    strb.flashRd   = isLoad & ~strb.specialRd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ  <= 1'b0;
      selQ <= 1'b0;
      cntQ <= '0;
    end else if (acceptWr) begin
      enQ  <= ctrlWrData[EN_BIT];
      selQ <= ctrlWrData[SEL_BIT];
      cntQ <= '0;
    end else if (strb.specialRd | strb.lockPgm | expire) begin
      enQ  <= 1'b0;
      selQ <= 1'b0;
      cntQ <= '0;
    end else if (anySet) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign ctrlBits = {selQ, enQ};

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= STORE_LAST); // R5
  AST_BUSY_NO_ARM: assert property (@(posedge clk) disable iff (!rstN)
    (eepromBusy && ctrlBits == 2'b00) |=> ctrlBits == 2'b00); // R10
  AST_USE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.specialRd || strb.lockPgm) && !acceptWr) |=> ctrlBits == 2'b00); // R3
endmodule

// File: rtl/lfa_data.sv
module lfa_data
  import lock_fuse_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int LOCK_W = 6,
  parameter int PGM_LO = 2,
  parameter logic [LOCK_W-1:0] LOCK_INIT    = '1,
  parameter logic [DATA_W-1:0] FUSE_LO_INIT = 8'hE1,
  parameter logic [DATA_W-1:0] FUSE_HI_INIT = 8'h99
) (
  input  logic              clk,
  input  logic              rstN,
  input  lfaStrobe_t        strb,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opData,
  input  logic [DATA_W-1:0] flashRdData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam logic [ADDR_W-1:0] ADDR_FLO  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_LOCK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_FHI  = ADDR_W'(3);
  localparam int PAD_W = DATA_W - LOCK_W;

  logic [LOCK_W-1:0] lockQ, lockNext;
  logic [DATA_W-1:0] fuseLoQ, fuseHiQ, lockByte, specialData, rdNext;
  logic              isLockAddr;

  for (genvar i = 0; i < LOCK_W; i++) begin : gLockBit
    if (i >= PGM_LO) begin : gPgm
      assign lockNext[i] = lockQ[i] & ~(strb.lockPgm & ~opData[i]);
    end else begin : gHold
      assign lockNext[i] = lockQ[i];
    end
  end

  assign lockByte   = {{PAD_W{1'b1}}, lockQ};
  assign isLockAddr = (opAddr == ADDR_LOCK);

  always_comb begin
    if (opAddr == ADDR_FLO)      specialData = fuseLoQ;
    else if (isLockAddr)         specialData = lockByte;
    else if (opAddr == ADDR_FHI) specialData = fuseHiQ;
    else                         specialData = '1;
  end

  assign rdNext = strb.specialRd ? specialData : flashRdData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockQ   <= LOCK_INIT;
      fuseLoQ <= FUSE_LO_INIT;
      fuseHiQ <= FUSE_HI_INIT;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      lockQ   <= lockNext;
      rdValid <= strb.specialRd | strb.flashRd;
      if (strb.specialRd | strb.flashRd) rdData <= rdNext;
    end
  end

  AST_LOCK_MONO: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((~$past(lockQ)) & lockQ) == '0); // R9
  AST_RD_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(strb.specialRd || strb.flashRd)); // R11
  AST_LOCK_PAD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.specialRd && isLockAddr) |=> rdData[DATA_W-1:LOCK_W] == '1); // R7
endmodule

// File: rtl/lock_fuse_access.sv
module lock_fuse_access
  import lock_fuse_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 16,
  parameter int LOAD_WIN  = 3,
  parameter int STORE_WIN = 4,
  parameter logic [5:0]        LOCK_INIT    = 6'h3F,
  parameter logic [DATA_W-1:0] FUSE_LO_INIT = 8'hE1,
  parameter logic [DATA_W-1:0] FUSE_HI_INIT = 8'h99
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [DATA_W-1:0] ctrlWrData,
  input  logic              opValid,
  input  logic              opIsStore,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opData,
  input  logic              eepromBusy,
  input  logic [DATA_W-1:0] flashRdData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [1:0]        ctrlBits
);
  lfaStrobe_t strb;

  lfa_ctrl #(
    .DATA_W(DATA_W), .LOAD_WIN(LOAD_WIN), .STORE_WIN(STORE_WIN),
    .EN_BIT(0), .SEL_BIT(3)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .opValid(opValid), .opIsStore(opIsStore), .eepromBusy(eepromBusy),
    .strb(strb), .ctrlBits(ctrlBits)
  );

  lfa_data #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOCK_W(6), .PGM_LO(2),
    .LOCK_INIT(LOCK_INIT), .FUSE_LO_INIT(FUSE_LO_INIT), .FUSE_HI_INIT(FUSE_HI_INIT)
  ) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .opAddr(opAddr), .opData(opData),
    .flashRdData(flashRdData), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: tb/lock_fuse_access_tb_top.sv
`timescale 1ns/1ps
module lock_fuse_access_tb_top;
  localparam logic [7:0] FLO = 8'hE1;
  localparam logic [7:0] FHI = 8'h99;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWrEn = 1'b0;
  logic [7:0] ctrlWrData = '0;
  logic opValid = 1'b0, opIsStore = 1'b0, eepromBusy = 1'b0;
  logic [15:0] opAddr = '0;
  logic [7:0] opData = '0, flashRdData = '0;
  logic [7:0] rdData;
  logic rdValid;
  logic [1:0] ctrlBits;

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [7:0] expQ[$];
  string tagQ[$];
  logic [5:0] expLock = 6'h3F;

  always #2 clk = ~clk;

  lock_fuse_access dut_i (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .opValid(opValid), .opIsStore(opIsStore), .opAddr(opAddr), .opData(opData),
    .eepromBusy(eepromBusy), .flashRdData(flashRdData),
    .rdData(rdData), .rdValid(rdValid), .ctrlBits(ctrlBits)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pop expected read results as the design produces them
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) check(rdData, 8'hxx, "R11 unexpected read");
      else check(rdData, expQ.pop_front(), tagQ.pop_front());
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ctrlWrite(input logic [7:0] d);
    ctrlWrEn = 1'b1; ctrlWrData = d;
    @(negedge clk);
    ctrlWrEn = 1'b0; ctrlWrData = '0;
  endtask

  task automatic doLoad(input logic [15:0] a, input logic [7:0] fl,
                        input logic [7:0] exp, input string tag);
    opValid = 1'b1; opIsStore = 1'b0; opAddr = a; flashRdData = fl;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    opValid = 1'b0; opAddr = '0; flashRdData = '0;
  endtask

  task automatic doStore(input logic [15:0] a, input logic [7:0] d);
    opValid = 1'b1; opIsStore = 1'b1; opAddr = a; opData = d;
    @(negedge clk);
    opValid = 1'b0; opIsStore = 1'b0; opAddr = '0; opData = '0;
  endtask

  function automatic logic [7:0] lockByte();
    return {2'b11, expLock};
  endfunction

  task automatic readLock(input string tag);
    ctrlWrite(8'h09);
    doLoad(16'h0001, 8'h5A, lockByte(), tag);
    idle(1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #400000;
    compared++; mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    finishRun();
  end

  initial begin
    idle(3);
    check({6'b0, ctrlBits}, 8'h00, "R1 ctrl reset");
    check({7'b0, rdValid}, 8'h00, "R1 rdValid reset");
    rstN = 1'b1;
    idle(1);
    doLoad(16'h0001, 8'h3C, 8'h3C, "R11 unarmed load");
    idle(1);
    ctrlWrite(8'h09);
    check({6'b0, ctrlBits}, 8'h03, "R2 armed flags");
    doLoad(16'h0001, 8'h11, 8'hFF, "R1 R7 lock init k1");
    check({6'b0, ctrlBits}, 8'h00, "R3 clear after read");
    idle(1);
    ctrlWrite(8'h09); idle(2);
    doLoad(16'h0000, 8'h22, FLO, "R6 low fuse k3");
    ctrlWrite(8'h09); idle(1);
    doLoad(16'h0003, 8'h33, FHI, "R6 high fuse k2");
    ctrlWrite(8'h09);
    doLoad(16'h0002, 8'h44, 8'hFF, "R6 other address");
    ctrlWrite(8'h09); idle(3);
    doLoad(16'h0001, 8'h55, 8'h55, "R5 load at k4 is flash");
    check({6'b0, ctrlBits}, 8'h00, "R5 cleared at k4");
    ctrlWrite(8'h09); idle(3);
    check({6'b0, ctrlBits}, 8'h03, "R5 still armed k3");
    idle(1);
    check({6'b0, ctrlBits}, 8'h00, "R5 auto clear");
    ctrlWrite(8'h01);
    check({6'b0, ctrlBits}, 8'h01, "R2 enable only");
    doLoad(16'h0001, 8'h66, 8'h66, "R2 not armed flash");
    idle(4);
    ctrlWrite(8'h09); idle(3);
    doStore(16'h1234, 8'hDB);
    expLock = 6'h1B;
    check({6'b0, ctrlBits}, 8'h00, "R4 clear after store");
    readLock("R8 store k4 programs");
    ctrlWrite(8'h09); idle(4);
    doStore(16'h0000, 8'hC0);
    readLock("R4 late store ignored");
    ctrlWrite(8'h09);
    eepromBusy = 1'b1;
    doLoad(16'h0001, 8'h77, 8'h77, "R10 busy load flash");
    doStore(16'h0001, 8'hC0);
    eepromBusy = 1'b0;
    idle(4);
    readLock("R10 busy store ignored");
    eepromBusy = 1'b1;
    ctrlWrite(8'h09);
    check({6'b0, ctrlBits}, 8'h00, "R10 busy blocks write");
    eepromBusy = 1'b0;
    ctrlWrite(8'h09);
    doStore(16'h0001, 8'hFF);
    readLock("R9 no bit returns to 1");
    ctrlWrite(8'h09); idle(1);
    doStore(16'h0001, 8'hC0);
    expLock = 6'h03;
    readLock("R8 low lock bits untouched");
    ctrlWrite(8'h09); idle(2);
    ctrlWrite(8'h09); idle(2);
    check({6'b0, ctrlBits}, 8'h03, "R12 rearm restarts");
    doLoad(16'h0000, 8'h88, FLO, "R12 rearm k3 special");
    ctrlWrite(8'h09);
    rstN = 1'b0; idle(1);
    check({6'b0, ctrlBits}, 8'h00, "R13 reset in window");
    rstN = 1'b1;
    expLock = 6'h3F;
    doLoad(16'h0001, 8'h99, 8'h99, "R13 window closed");
    readLock("R1 lock back to init");
    idle(2);
    check(8'(expQ.size()), 8'h00, "R3 all reads returned");
    finishRun();
  end
endmodule